// File: doc/BRIEF.md
# Always-on day-time counter with delayed field commits

This block keeps wall-clock time as four live fields: seconds, minutes, hours and a 16-bit day count. A one-cycle `tick` pulse advances them once per second. Software cannot load the live fields directly. Instead it writes a staging register for each field. That field's live value changes only after a fixed, programmable number of clock cycles. The delay stands in for the slow hand-off into an always-on supply region.

Every field that lands sets its own bit in a raw status word. Software clears these bits by writing ones to a clear register. An enable register filters the raw status into a masked view. A power-status register comes out of reset, which stands for loss of always-on power, holding a marker value that means "time not valid". Software overwrites that marker through a control register once it has loaded a good time. Access uses a simple valid/write/address/data bus with combinational read data.

Top module: `rtc_daytime_core`

## Requirements
- R1: Live seconds (6 bits), minutes (6 bits), hours (5 bits) and days (16 bits) read zero-extended at offsets 0x00, 0x04, 0x08 and 0x0C. After reset all four are zero.
- R2: A write to 0x10, 0x14, 0x18 or 0x1C stores a staged value for seconds, minutes, hours or days. The staged value reads back at the same offset. The live field keeps its old value for COMMIT_CYCLES-1 clock edges after the write edge and takes the staged value on edge COMMIT_CYCLES.
- R3: On the edge where a field commits, the raw status register at 0x34 sets bit 8 for seconds, bit 9 for minutes, bit 10 for hours or bit 11 for days. After reset it reads zero.
- R4: Writing 0x38 clears every raw status bit whose write-data bit is one. Zero bits have no effect. A commit in the same cycle keeps its bit set.
- R5: The enable register at 0x30 stores 16 bits and reads back. Offset 0x3C reads raw status AND enable.
- R6: After reset the power-status register at 0x5C reads 0x0096, which marks the time as invalid.
- R7: A write to 0x58 clears each low-byte bit of the power status where write-data bits 7:0 are one. It also loads write-data bits 15:8 into the high byte. An all-zero low byte leaves the low byte unchanged.
- R8: On a tick, seconds count up and wrap from 59 (or above) to 0. The wrap carries into minutes, which also wrap at 59. Minutes carry into hours, which wrap at 23. Hours carry into days. All carries happen on that same tick.
- R9: From day 65535 at 23:59:59, a tick gives day 0 at 00:00:00.
- R10: When a commit and a tick hit the same edge, the committed value wins for that field. Carries into the other fields are still taken from the pre-tick live values.
- R11: A write to a staging register whose commit is still pending replaces the staged value and restarts the full delay. The earlier value never reaches the live field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models always-on power loss |
| tick | input | 1 | One-cycle one-second advance pulse |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (8) | Byte offset |
| bus_wdata | input | DW (16) | Write data |
| bus_rdata | output | DW (16) | Read data for bus_addr, combinational |

## Verification
The hardest case to reach from the ports is a commit and a tick, or a commit and a status clear, falling on exactly the same clock edge. The commit edge sits COMMIT_CYCLES edges after a bus write and is not visible until it happens. The bench counts that many negative edges from the staging write, then raises the tick or the clear so that it spans the commit edge. Restaging is covered by rewriting a field partway through its delay and watching the live value hold through the edge where the first commit would have landed.

// File: rtl/rtc_daytime_core.sv
module rtc_daytime_core #(
  parameter int COMMIT_CYCLES = 6250000,
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata
);
  localparam int CW = $clog2(COMMIT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(COMMIT_CYCLES);
  localparam int NF = 4;

  logic [5:0]    sec_q, min_q;
  logic [4:0]    hr_q;
  logic [15:0]   day_q;
  logic [DW-1:0] stg_q [NF];
  logic [CW-1:0] cnt_q [NF];
  logic [NF-1:0] pend_q, stg_wr, cmt;
  logic [DW-1:0] raw_q, en_q, pwr_q;

  wire wr     = bus_valid & bus_write;
  wire clr_wr = wr && bus_addr == AW'(8'h38);
  wire en_wr  = wr && bus_addr == AW'(8'h30);
  wire pwr_wr = wr && bus_addr == AW'(8'h58);

  for (genvar i = 0; i < NF; i++) begin : g_fld
    assign stg_wr[i] = wr && bus_addr == AW'(16 + 4 * i);
    assign cmt[i]    = pend_q[i] && cnt_q[i] == CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        stg_q[i] <= '0;
        cnt_q[i] <= '0;
      end
      pend_q <= '0;
    end else begin
      for (int i = 0; i < NF; i++) begin
        if (stg_wr[i]) begin
          stg_q[i]  <= bus_wdata;
          cnt_q[i]  <= LOAD;
          pend_q[i] <= 1'b1;
        end else if (pend_q[i]) begin
          cnt_q[i] <= cnt_q[i] - CW'(1);
          if (cmt[i]) pend_q[i] <= 1'b0;
        end
      end
    end
  end

  wire sec_w = sec_q >= 6'd59;
  wire min_w = min_q >= 6'd59;
  wire hr_w  = hr_q >= 5'd23;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
    end else begin
      if (cmt[0])     sec_q <= stg_q[0][5:0];
      else if (tick)  sec_q <= sec_w ? 6'd0 : sec_q + 6'd1;
      if (cmt[1])                 min_q <= stg_q[1][5:0];
      else if (tick && sec_w)     min_q <= min_w ? 6'd0 : min_q + 6'd1;
      if (cmt[2])                      hr_q <= stg_q[2][4:0];
      else if (tick && sec_w && min_w) hr_q <= hr_w ? 5'd0 : hr_q + 5'd1;
      if (cmt[3])                             day_q <= stg_q[3][15:0];
      else if (tick && sec_w && min_w && hr_w) day_q <= day_q + 16'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '0;
      pwr_q <= DW'(16'h0096);
    end else begin
      raw_q <= (raw_q & ~(clr_wr ? bus_wdata : '0)) | (DW'(cmt) << 8);
      if (en_wr)  en_q  <= bus_wdata;
      if (pwr_wr) pwr_q <= {bus_wdata[15:8], pwr_q[7:0] & ~bus_wdata[7:0]};
    end
  end

  always_comb begin
    case (bus_addr)
      AW'(8'h00): bus_rdata = DW'(sec_q);
      AW'(8'h04): bus_rdata = DW'(min_q);
      AW'(8'h08): bus_rdata = DW'(hr_q);
      AW'(8'h0C): bus_rdata = DW'(day_q);
      AW'(8'h10): bus_rdata = stg_q[0];
      AW'(8'h14): bus_rdata = stg_q[1];
      AW'(8'h18): bus_rdata = stg_q[2];
      AW'(8'h1C): bus_rdata = stg_q[3];
      AW'(8'h30): bus_rdata = en_q;
      AW'(8'h34): bus_rdata = raw_q;
      AW'(8'h3C): bus_rdata = raw_q & en_q;
      AW'(8'h5C): bus_rdata = pwr_q;
      default:    bus_rdata = '0;
    endcase
  end

  a_r2_sec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cmt[0]) |=> $stable(sec_q));

  a_r3_commit_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|cmt) |=> ((raw_q[11:8] & $past(cmt)) == $past(cmt)));

  a_r4_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && bus_wdata[8] && !cmt[0]) |=> !raw_q[8]);

  a_r7_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_wr |=> $stable(pwr_q));

  a_r9_day_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sec_q == 6'd59 && min_q == 6'd59 && hr_q == 5'd23 && cmt == '0)
    |=> (hr_q == 5'd0 && day_q == $past(day_q) + 16'd1));
endmodule

// File: tb/rtc_daytime_core_test.sv
`timescale 1ns/1ps
module rtc_daytime_core_test;
  localparam int D = 20;
  logic clk = 0, rst_n = 0, tick = 0, bus_valid = 0, bus_write = 0;
  logic [7:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  int checks = 0, errors = 0;

  rtc_daytime_core #(.COMMIT_CYCLES(D), .AW(8), .DW(16)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata));

  always #10 clk = ~clk;

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic expect_rd(input string tag, input logic [7:0] a, input logic [15:0] e);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== e) begin
      errors++;
      $display("FAIL %s addr %h got %h expected %h", tag, a, bus_rdata, e);
    end
    bus_valid = 0;
  endtask

  task automatic pulse_tick();
    tick = 1; @(negedge clk); tick = 0;
  endtask

  task automatic set_time(input logic [15:0] d, h, m, s);
    wr(8'h10, s); wr(8'h14, m); wr(8'h18, h); wr(8'h1C, d);
    repeat (D + 4) @(negedge clk);
  endtask

  task automatic expect_time(input string tag, input logic [15:0] d, h, m, s);
    expect_rd(tag, 8'h00, s); expect_rd(tag, 8'h04, m);
    expect_rd(tag, 8'h08, h); expect_rd(tag, 8'h0C, d);
  endtask

  task automatic t_reset();
    expect_time("R1 reset", 0, 0, 0, 0);
    expect_rd("R3 reset raw", 8'h34, 16'h0000);
    expect_rd("R6 reset power", 8'h5C, 16'h0096);
  endtask

  task automatic t_commit();
    wr(8'h10, 16'd42);
    expect_rd("R2 staged readback", 8'h10, 16'd42);
    repeat (D - 1) @(negedge clk);
    expect_rd("R2 before commit", 8'h00, 16'd0);
    expect_rd("R3 before commit", 8'h34, 16'h0000);
    @(negedge clk);
    expect_rd("R2 after commit", 8'h00, 16'd42);
    expect_rd("R3 sec flag", 8'h34, 16'h0100);
  endtask

  task automatic t_clear();
    wr(8'h38, 16'h0000);
    expect_rd("R4 zero write", 8'h34, 16'h0100);
    wr(8'h38, 16'h0100);
    expect_rd("R4 one clears", 8'h34, 16'h0000);
    wr(8'h14, 16'd7);
    repeat (D - 1) @(negedge clk);
    wr(8'h38, 16'h0200);
    expect_rd("R4 commit beats clear", 8'h34, 16'h0200);
    expect_rd("R1 minutes", 8'h04, 16'd7);
    wr(8'h38, 16'hFFFF);
    expect_rd("R4 clear all", 8'h34, 16'h0000);
  endtask

  task automatic t_enable();
    set_time(16'd1, 16'd2, 16'd3, 16'd4);
    expect_rd("R3 all flags", 8'h34, 16'h0F00);
    wr(8'h30, 16'h0500);
    expect_rd("R5 enable readback", 8'h30, 16'h0500);
    expect_rd("R5 masked", 8'h3C, 16'h0500);
    wr(8'h30, 16'h0000);
    expect_rd("R5 masked off", 8'h3C, 16'h0000);
  endtask

  task automatic t_tick();
    set_time(16'd5, 16'd23, 16'd59, 16'd59);
    pulse_tick();
    expect_time("R8 full carry", 16'd6, 0, 0, 0);
    pulse_tick();
    expect_rd("R8 plain second", 8'h00, 16'd1);
    set_time(16'd0, 16'd3, 16'd10, 16'd59);
    pulse_tick();
    expect_time("R8 minute carry", 16'd0, 16'd3, 16'd11, 16'd0);
  endtask

  task automatic t_daywrap();
    set_time(16'hFFFF, 16'd23, 16'd59, 16'd59);
    pulse_tick();
    expect_time("R9 day wrap", 0, 0, 0, 0);
  endtask

  task automatic t_collision();
    set_time(16'd2, 16'd4, 16'd10, 16'd59);
    wr(8'h10, 16'd30);
    repeat (D - 1) @(negedge clk);
    pulse_tick();
    expect_rd("R10 commit wins", 8'h00, 16'd30);
    expect_rd("R10 carry kept", 8'h04, 16'd11);
  endtask

  task automatic t_restage();
    wr(8'h10, 16'd5);
    repeat (8) @(negedge clk);
    wr(8'h10, 16'd9);
    repeat (D - 1) @(negedge clk);
    expect_rd("R11 old value held", 8'h00, 16'd30);
    @(negedge clk);
    expect_rd("R11 new value", 8'h00, 16'd9);
  endtask

  task automatic t_power();
    wr(8'h58, 16'h0000);
    expect_rd("R7 zero write", 8'h5C, 16'h0096);
    wr(8'h58, 16'h00FF);
    expect_rd("R7 low clear", 8'h5C, 16'h0000);
    wr(8'h58, 16'h6900);
    expect_rd("R7 valid mark", 8'h5C, 16'h6900);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_commit();
    t_clear();
    t_enable();
    t_tick();
    t_daywrap();
    t_collision();
    t_restage();
    t_power();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule